// File: doc/BRIEF.md
# Flash Page-Buffer Program Controller

This block lets firmware rewrite any subset of bytes in one page of an on-chip non-volatile code array. The storage is divided into 1 kB sectors of 64-byte pages, and here it is modelled as an internal byte memory that resets to the erased value 0xFF. Firmware works through four byte-wide registers on a simple write/read bus. It sets a byte offset and fills a 64-byte page buffer through the data register. The offset advances by itself after each load, and the controller remembers which buffer bytes were filled. Firmware then writes a command code to the control register.

On an erase-program command, the filled bytes replace the matching bytes of the target page. On a program-only command, bits can only go from 1 to 0. Bytes that were not filled keep their old contents. Either operation runs for a timed busy interval, and the array is updated when that interval ends. The same address registers that gave the load offset also name the target page at command time. The control register reads back as status and is written as a command. Writing any command clears the status before the new outcome is recorded.

Two conditions refuse an erase or program. One is a brown-out flag from the supply monitor. The other is a per-sector lock vector. A separate read port exposes the array contents. Bus writes are accepted in the cycle they are presented and there is no back-pressure. Reads are combinational and have no side effects.

Top module: `fpc_top`

## Requirements
- R1: After reset the status reads 0x00, both address registers read 0x00 and every array byte reads 0xFF.
- R2: Register offsets on `bus_addr` are 0 control/status, 1 address low, 2 address high and 3 data. The address registers read back what was written. At command time, the target page is the 16-bit value {high, low} with its 6 offset bits dropped, truncated to the array size.
- R3: A write to the data register places the byte in the page buffer at offset low[5:0] and marks that lane as loaded. It then advances low[5:0] by one modulo 64 and leaves low[7:6] unchanged.
- R4: Command 0x68 (erase-program) sets each loaded byte of the target page to its buffer value. Every other byte of the array is left unchanged.
- R5: Command 0x08 (program-only) sets each loaded byte of the target page to the old value AND the buffer value. Every other byte is left unchanged.
- R6: After an accepted 0x08 the busy bit (status bit 7) stays high for exactly PROG_CYCLES = 2*CLK_KHZ cycles; after 0x68 it stays high for ERPG_CYCLES = 4*CLK_KHZ cycles. The array does not change while busy is high. Status then reads 0x01 (done, bit 0).
- R7: Completion of a timed operation clears all loaded marks, so a later command with no new loads changes no byte.
- R8: Command 0x00 discards the buffer contents and loaded marks at once and sets status to 0x01 without going busy.
- R9: Any other command code sets status to 0x08 (error, bit 3) and starts nothing.
- R10: While `brownout` is high, 0x68 and 0x08 set status to 0x08 and leave the array and the loaded marks unchanged.
- R11: When the target sector's bit in `sec_lock` is set, 0x68 and 0x08 set status to 0x02 (security, bit 1) and leave the array and the loaded marks unchanged.
- R12: Every accepted command clears bits 3, 1 and 0 before recording its own outcome.
- R13: While busy, all writes to the control, address and data registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| brownout | input | 1 | Supply-low flag; blocks erase and program |
| sec_lock | input | NUM_SECTORS | Per-sector write lock |
| rd_addr | input | ARR_AW | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The bench builds the block with CLK_KHZ = 10, which gives 20-cycle program-only and 40-cycle erase-program intervals. With intervals that short, each timed operation can run to completion and be cycle-counted many times within budget. It keeps 64-byte pages and two 1 kB sectors. The offset wrap from 63 back to 0 is therefore reachable, and the random lock vector can protect one sector while the other stays writable. With 2048 bytes of storage, the whole array can be compared after reset.

// File: rtl/fpc_pkg.sv
`timescale 1ns/1ps
package fpc_pkg;
  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_ADRLO = 2'd1;
  localparam logic [1:0] REG_ADRHI = 2'd2;
  localparam logic [1:0] REG_DATA  = 2'd3;

  localparam logic [7:0] CMD_CLEAR = 8'h00;
  localparam logic [7:0] CMD_ERPG  = 8'h68;
  localparam logic [7:0] CMD_PROG  = 8'h08;

  localparam int ST_BUSY = 7;
  localparam int ST_ERR  = 3;
  localparam int ST_SEC  = 1;
  localparam int ST_DONE = 0;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PROG = 2'd1,
    SEQ_ERPG = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fpc_page_buf.sv
`timescale 1ns/1ps
module fpc_page_buf #(
  parameter int PAGE_BYTES = 64,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en,
  input  logic [OFF_W-1:0]        ld_off,
  input  logic [7:0]              ld_data,
  input  logic                    clr,
  output logic [PAGE_BYTES*8-1:0] buf_data,
  output logic [PAGE_BYTES-1:0]   buf_valid
);
  for (genvar ln = 0; ln < PAGE_BYTES; ln++) begin : g_lane
    logic [7:0] byte_q;
    logic       vld_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        byte_q <= 8'h00;
        vld_q  <= 1'b0;
      end else if (ld_en && ld_off == OFF_W'(ln)) begin
        byte_q <= ld_data;
        vld_q  <= 1'b1;
      end
    end
    assign buf_data[ln*8 +: 8] = byte_q;
    assign buf_valid[ln]       = vld_q;
  end
endmodule

// File: rtl/fpc_sequencer.sv
`timescale 1ns/1ps
module fpc_sequencer
  import fpc_pkg::*;
#(
  parameter int PROG_CYCLES = 400000,
  parameter int ERPG_CYCLES = 800000,
  localparam int TW = $clog2(ERPG_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_code,
  input  logic       brownout,
  input  logic       sec_hit,
  output logic       busy,
  output logic [7:0] status,
  output logic       commit,
  output logic       commit_erase,
  output logic       buf_clr
);
  seq_state_e    state_q;
  logic [TW-1:0] timer_q;
  logic          err_q, sec_q, done_q;
  logic          accept, is_clr, is_erpg, is_prog;

  always_comb begin
    busy         = (state_q != SEQ_IDLE);
    accept       = cmd_we && !busy;
    is_clr       = (cmd_code == CMD_CLEAR);
    is_erpg      = (cmd_code == CMD_ERPG);
    is_prog      = (cmd_code == CMD_PROG);
    commit       = busy && (timer_q == '0);
    commit_erase = (state_q == SEQ_ERPG);
    buf_clr      = (accept && is_clr) || commit;
    status           = 8'h00;
    status[ST_BUSY]  = busy;
    status[ST_ERR]   = err_q;
    status[ST_SEC]   = sec_q;
    status[ST_DONE]  = done_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      timer_q <= '0;
      err_q   <= 1'b0;
      sec_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (accept) begin
      err_q  <= 1'b0;
      sec_q  <= 1'b0;
      done_q <= 1'b0;
      if (is_clr) begin
        done_q <= 1'b1;
      end else if (!(is_erpg || is_prog)) begin
        err_q <= 1'b1;
      end else if (brownout) begin
        err_q <= 1'b1;
      end else if (sec_hit) begin
        sec_q <= 1'b1;
      end else if (is_erpg) begin
        state_q <= SEQ_ERPG;
        timer_q <= TW'(ERPG_CYCLES - 1);
      end else begin
        state_q <= SEQ_PROG;
        timer_q <= TW'(PROG_CYCLES - 1);
      end
    end else if (commit) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b1;
    end else if (busy) begin
      timer_q <= timer_q - 1'b1;
    end
  end
endmodule

// File: rtl/fpc_array.sv
`timescale 1ns/1ps
module fpc_array #(
  parameter int DEPTH      = 2048,
  parameter int PAGE_BYTES = 64,
  localparam int AW        = $clog2(DEPTH),
  localparam int NUM_PAGES = DEPTH / PAGE_BYTES,
  localparam int PAGE_W    = $clog2(NUM_PAGES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic                    erase,
  input  logic [PAGE_W-1:0]       page,
  input  logic [PAGE_BYTES*8-1:0] buf_data,
  input  logic [PAGE_BYTES-1:0]   buf_valid,
  input  logic [AW-1:0]           rd_addr,
  output logic [7:0]              rd_data
);
  logic [7:0] mem [DEPTH];

  for (genvar pg = 0; pg < NUM_PAGES; pg++) begin : g_page
    logic hit;
    assign hit = commit && (page == PAGE_W'(pg));
    for (genvar ln = 0; ln < PAGE_BYTES; ln++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mem[pg*PAGE_BYTES + ln] <= 8'hFF;
        end else if (hit && buf_valid[ln]) begin
          mem[pg*PAGE_BYTES + ln] <= erase ? buf_data[ln*8 +: 8]
                                           : (mem[pg*PAGE_BYTES + ln] & buf_data[ln*8 +: 8]);
        end
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fpc_top.sv
`timescale 1ns/1ps
module fpc_top
  import fpc_pkg::*;
#(
  parameter int PAGE_BYTES   = 64,
  parameter int SECTOR_BYTES = 1024,
  parameter int NUM_SECTORS  = 2,
  parameter int CLK_KHZ      = 200000,
  localparam int DEPTH       = SECTOR_BYTES * NUM_SECTORS,
  localparam int ARR_AW      = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [1:0]             bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic                   brownout,
  input  logic [NUM_SECTORS-1:0] sec_lock,
  input  logic [ARR_AW-1:0]      rd_addr,
  output logic [7:0]             rd_data
);
  localparam int OFF_W       = $clog2(PAGE_BYTES);
  localparam int PAGE_W      = $clog2(DEPTH / PAGE_BYTES);
  localparam int SEC_LSB     = $clog2(SECTOR_BYTES);
  localparam int SEC_W       = $clog2(NUM_SECTORS);
  localparam int PROG_CYCLES = 2 * CLK_KHZ;
  localparam int ERPG_CYCLES = 4 * CLK_KHZ;

  logic [7:0]              adr_lo_q, adr_hi_q;
  logic [7:0]              status;
  logic                    busy, commit, commit_erase, buf_clr;
  logic                    wr_any, wr_ok, ld_en, cmd_we, sec_hit;
  logic [PAGE_W-1:0]       tgt_page;
  logic [SEC_W-1:0]        sec_idx;
  logic [PAGE_BYTES*8-1:0] buf_data;
  logic [PAGE_BYTES-1:0]   buf_valid;

  assign wr_any   = bus_sel && bus_we;
  assign wr_ok    = wr_any && !busy;
  assign ld_en    = wr_ok && (bus_addr == REG_DATA);
  assign cmd_we   = wr_any && (bus_addr == REG_CTRL);
  assign tgt_page = PAGE_W'({adr_hi_q, adr_lo_q} >> OFF_W);
  assign sec_idx  = SEC_W'({adr_hi_q, adr_lo_q} >> SEC_LSB);
  assign sec_hit  = sec_lock[sec_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_lo_q <= 8'h00;
      adr_hi_q <= 8'h00;
    end else if (wr_ok) begin
      case (bus_addr)
        REG_ADRLO: adr_lo_q <= bus_wdata;
        REG_ADRHI: adr_hi_q <= bus_wdata;
        REG_DATA:  adr_lo_q[OFF_W-1:0] <= adr_lo_q[OFF_W-1:0] + 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      REG_CTRL:  bus_rdata = status;
      REG_ADRLO: bus_rdata = adr_lo_q;
      REG_ADRHI: bus_rdata = adr_hi_q;
      default:   bus_rdata = 8'h00;
    endcase
  end

  fpc_page_buf #(.PAGE_BYTES(PAGE_BYTES)) i_buf (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en),
    .ld_off(adr_lo_q[OFF_W-1:0]), .ld_data(bus_wdata), .clr(buf_clr),
    .buf_data(buf_data), .buf_valid(buf_valid)
  );

  fpc_sequencer #(.PROG_CYCLES(PROG_CYCLES), .ERPG_CYCLES(ERPG_CYCLES)) i_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(bus_wdata),
    .brownout(brownout), .sec_hit(sec_hit), .busy(busy), .status(status),
    .commit(commit), .commit_erase(commit_erase), .buf_clr(buf_clr)
  );

  fpc_array #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES)) i_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .erase(commit_erase),
    .page(tgt_page), .buf_data(buf_data), .buf_valid(buf_valid),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/fpc_checker.sv
`timescale 1ns/1ps
module fpc_checker
  import fpc_pkg::*;
#(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          brownout,
  input logic          sec_hit,
  input logic [7:0]    status,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data
);
  logic cmd_acc, is_pg, is_known;
  assign cmd_acc  = bus_sel && bus_we && (bus_addr == REG_CTRL) && !status[ST_BUSY];
  assign is_pg    = (bus_wdata == CMD_ERPG) || (bus_wdata == CMD_PROG);
  assign is_known = is_pg || (bus_wdata == CMD_CLEAR);

  a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && bus_wdata == CMD_CLEAR) |=> status == 8'h01);

  a_r9_unknown_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && !is_known) |=> status == 8'h08);

  a_r10_brownout_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && is_pg && brownout) |=> status == 8'h08);

  a_r11_secured_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_acc && is_pg && !brownout && sec_hit) |=> status == 8'h02);

  a_r12_busy_clean: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_BUSY] |-> (status[3:0] == 4'h0));

  a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[ST_BUSY]) |-> status[ST_DONE]);

  a_r6_array_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_BUSY] && $past(status[ST_BUSY]) && rd_addr == $past(rd_addr))
      |-> rd_data == $past(rd_data));

  a_r13_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_BUSY] && bus_sel && bus_we && bus_addr == REG_CTRL)
      |=> (status[ST_BUSY] || status == 8'h01));
endmodule

bind fpc_top fpc_checker #(.AW(ARR_AW)) i_fpc_checker (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .brownout(brownout),
  .sec_hit(sec_hit), .status(status), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_fpc_top.sv
`timescale 1ns/1ps
module test_fpc_top;
  localparam int PB = 64, SB = 1024, NS = 2, KHZ = 10;
  localparam int DEPTH = NS * SB, AW = $clog2(DEPTH);
  localparam int PROG_N = 2 * KHZ, ERPG_N = 4 * KHZ;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [7:0]    bus_wdata = 8'h00;
  logic [7:0]    bus_rdata;
  logic          brownout = 1'b0;
  logic [NS-1:0] sec_lock = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;

  int         n_chk = 0, n_fail = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] bdat [PB];
  bit         bval [PB];
  logic [7:0] cur_lo = 8'h00, cur_hi = 8'h00;

  fpc_top #(.PAGE_BYTES(PB), .SECTOR_BYTES(SB), .NUM_SECTORS(NS), .CLK_KHZ(KHZ)) i_fpc_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .brownout(brownout), .sec_lock(sec_lock), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic set_addr(input int a);
    cur_lo = a[7:0]; cur_hi = a[15:8];
    wr(2'd1, cur_lo);
    wr(2'd2, cur_hi);
  endtask

  task automatic load(input logic [7:0] d);
    wr(2'd3, d);
    bdat[cur_lo[5:0]] = d;
    bval[cur_lo[5:0]] = 1'b1;
    cur_lo[5:0] = cur_lo[5:0] + 6'd1;
  endtask

  function automatic int page_base();
    return ({cur_hi, cur_lo} & (DEPTH - 1)) & ~(PB - 1);
  endfunction

  task automatic wait_idle(output int cyc, output logic [7:0] s);
    cyc = 0;
    rd(2'd0, s);
    while (s[7] && cyc < 1000) begin
      cyc++;
      @(negedge clk);
      rd(2'd0, s);
    end
  endtask

  // Runs a command and checks status and busy length against the requirement model
  task automatic do_cmd(input logic [7:0] code, input string tag);
    logic [7:0] exp_s, s;
    int exp_c, cyc, base;
    bit pg, erase;
    base  = page_base();
    pg    = (code == 8'h68) || (code == 8'h08);
    erase = (code == 8'h68);
    exp_c = 0;
    if (code == 8'h00) begin
      exp_s = 8'h01;
      for (int i = 0; i < PB; i++) bval[i] = 1'b0;
    end else if (!pg) exp_s = 8'h08;
    else if (brownout) exp_s = 8'h08;
    else if (sec_lock[base / SB]) exp_s = 8'h02;
    else begin
      exp_s = 8'h01;
      exp_c = erase ? ERPG_N : PROG_N;
      for (int i = 0; i < PB; i++) if (bval[i]) begin
        model[base + i] = erase ? bdat[i] : (model[base + i] & bdat[i]);
        bval[i] = 1'b0;
      end
    end
    wr(2'd0, code);
    wait_idle(cyc, s);
    chk(cyc == exp_c, {tag, " R6 busy length"}, cyc, exp_c);
    chk(s == exp_s, {tag, " status"}, s, exp_s);
  endtask

  task automatic check_range(input int base, input int len, input string tag);
    int bad = 0, first_a = 0, first_v = 0, first_e = 0;
    for (int i = 0; i < len; i++) begin
      rd_addr = AW'(base + i);
      #0.1;
      if (rd_data !== model[base + i]) begin
        if (bad == 0) begin first_a = base + i; first_v = rd_data; first_e = model[base + i]; end
        bad++;
      end
    end
    chk(bad == 0, $sformatf("%s array @0x%0h", tag, first_a), first_v, first_e);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] s;
    int base;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    for (int i = 0; i < PB; i++) begin bdat[i] = 8'h00; bval[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, s); chk(s == 8'h00, "R1 status", s, 8'h00);
    rd(2'd1, s); chk(s == 8'h00, "R1 addr low", s, 8'h00);
    rd(2'd2, s); chk(s == 8'h00, "R1 addr high", s, 8'h00);
    check_range(0, DEPTH, "R1 erased");

    // R2 address registers read back
    set_addr(16'h1234);
    rd(2'd1, s); chk(s == 8'h34, "R2 addr low readback", s, 8'h34);
    rd(2'd2, s); chk(s == 8'h12, "R2 addr high readback", s, 8'h12);

    // R3 offset wrap with upper low bits kept; R4 erase-program on page 1
    set_addr(16'h007E);
    load(8'hA1); load(8'hB2); load(8'hC3);
    rd(2'd1, s); chk(s == 8'h41, "R3 offset wrap", s, 8'h41);
    do_cmd(8'h68, "R4 erase-program");
    check_range(0, 3 * PB, "R4 loaded lanes only");

    // R5 program-only ANDs into old contents
    set_addr(16'h0040);
    load(8'h0F); load(8'hF0);
    set_addr(16'h007F);
    load(8'h3C);
    do_cmd(8'h08, "R5 program-only");
    check_range(PB, PB, "R5 AND result");

    // R7 marks cleared after completion
    set_addr(16'h0040);
    do_cmd(8'h68, "R7 no loads");
    check_range(PB, PB, "R7 page unchanged");

    // R8 clear command discards loads
    set_addr(16'h0080);
    load(8'h11); load(8'h22);
    do_cmd(8'h00, "R8 clear");
    do_cmd(8'h68, "R8 after clear");
    check_range(2 * PB, PB, "R8 page unchanged");

    // R9 unknown code
    do_cmd(8'h55, "R9 unknown");

    // R12 a valid command clears the error bit
    do_cmd(8'h00, "R12 clears error");

    // R10 brown-out blocks, loads kept
    set_addr(16'h00C0);
    load(8'h5A);
    brownout = 1'b1;
    do_cmd(8'h68, "R10 brownout");
    check_range(3 * PB, PB, "R10 array unchanged");
    brownout = 1'b0;
    do_cmd(8'h68, "R10 retained loads commit");
    check_range(3 * PB, PB, "R10 later commit");

    // R11 secured sector
    sec_lock = 2'b10;
    set_addr(16'h0440);
    load(8'h77);
    do_cmd(8'h08, "R11 secured");
    check_range(SB, PB, "R11 array unchanged");
    do_cmd(8'h00, "R11 drop loads");
    sec_lock = 2'b00;

    // R13 writes while busy ignored
    set_addr(16'h0100);
    load(8'hF3);
    base = page_base();
    model[base] = model[base] & 8'hF3;
    bval[0] = 1'b0;
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h55);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h99);
    begin
      int cyc;
      wait_idle(cyc, s);
    end
    chk(s == 8'h01, "R13 status after busy writes", s, 8'h01);
    rd(2'd1, s); chk(s == 8'h01, "R13 addr low kept", s, 8'h01);
    do_cmd(8'h68, "R13 no stray load");
    check_range(base, PB, "R13 page");

    // Random mix: R2 R4 R5 R9 R10 R11
    for (int it = 0; it < 24; it++) begin
      int n, r;
      logic [7:0] code;
      sec_lock = NS'($urandom % 4);
      brownout = ($urandom % 8) == 0;
      set_addr($urandom % 65536);
      n = 1 + $urandom % PB;
      for (int k = 0; k < n; k++) load(8'($urandom));
      r = $urandom % 8;
      code = (r < 4) ? 8'h68 : (r < 6) ? 8'h08 : (r == 6) ? 8'h00 : 8'($urandom | 1);
      do_cmd(code, $sformatf("R2 random op %0d", it));
      check_range(page_base(), PB, "R4 R5 random page");
    end
    brownout = 1'b0;
    check_range(0, DEPTH, "R4 R5 whole array");

    summary();
    $finish;
  end
endmodule